// File: doc/BRIEF.md
# Multiplexed Seven-Digit Display Scanner with Shared-Line Keys

This block drives a row of seven common-cathode seven-segment digits, lighting one digit at a time. It takes seven 4-bit digit codes from the surrounding logic. A slow scan tick steps the display from the most significant position (index 6) down to index 0. Leading zeros are blanked, but only above a fixed digit position. A decimal point is lit on a fixed position, and it is lit on every position while a lock flag is held. Brightness is lowered by showing only one scan frame out of every N.

The segment lines are shared with a small 2×2 pushbutton matrix. Before each digit slot, the block turns every digit and segment off. It then asserts two drive lines one after the other and reads two sense lines after a settling wait for each. The resulting 4-bit key pattern is debounced. Newly pressed keys are reported as single-cycle pulses. Key 0 is also used inside the block to step the brightness.

Top module: `led_scan_keys`

## Requirements
- R1: A digit slot starts every TICK_CYC clock cycles, and the slots visit positions 6, 5, 4, 3, 2, 1, 0 and then 6 again. During the display part of a slot exactly one bit of `dig_en_n` is low: bit i for position i. From reset until the first slot has been shown, all enables are high.
- R2: `seg` bits 0 to 6 are segments a to g and bit 7 is the decimal point. Codes 0 to 9 show the usual numeral shapes. Code 11 shows g alone (minus). Codes 10 and 12 to 15 show no segment.
- R3: A zero flag is set at the start of every frame. A code of 0 is blanked while the flag is set, and any nonzero code (including 10 to 15) clears the flag. At position 2 the flag is cleared unconditionally, so positions 2, 1 and 0 are never blanked as leading zeros.
- R4: In a displayed frame, the decimal point is lit on position 2. While `lock_on` is high it is lit on every position, including blanked leading zeros.
- R5: Brightness setting B runs from 1 to BRIGHT_MAX. Each frame that ends with the frame counter at zero reloads it with B, and every frame end decrements it. A frame is displayed only when the counter is zero at its slots. Otherwise all `seg` bits are 0 while the enables keep scanning. The result is one displayed frame in every B.
- R6: Each slot begins with `key_drv`=01 for SETTLE_CYC cycles and then `key_drv`=10 for SETTLE_CYC cycles. All enables are high and all segments low throughout. `key_sense` is sampled in the last cycle of each drive. Key number = 2×group + sense bit, where group 0 is `key_drv`=01.
- R7: A key pattern is accepted once it has been sampled in DEB_SAMPLES consecutive slots. Patterns that change earlier are never accepted, and a held pattern is accepted only once.
- R8: When a pattern is accepted, `key_press` pulses for the one cycle at the start of the display part. It pulses only for keys that are 1 in the new pattern and were 0 in the previously accepted one. Releases pulse nothing.
- R9: An accepted press of key 0 raises the brightness setting by one, and BRIGHT_MAX wraps to 1. If the press is accepted in the position-0 slot, that frame's reload uses the setting from before the press.
- R10: After reset the brightness is 1, the frame counter is 0, no key is accepted, the next position is 6, and `key_drv`, `seg` and `key_press` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_codes | input | 28 | Code of position i in bits 4i+3:4i |
| lock_on | input | 1 | Light every decimal point |
| key_sense | input | 2 | Key matrix sense lines |
| dig_en_n | output | 7 | Active-low digit enables, bit i = position i |
| seg | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |
| key_drv | output | 2 | Key matrix drive lines, one group at a time |
| key_press | output | 4 | One-cycle pulse per newly pressed key |

## Verification
Two events can land in the same slot: a dim keypress being accepted, and the frame-end reload of the brightness counter in the position-0 slot. The bench arranges this on purpose. It holds key 0 released long enough to clear its accepted state, then presses it exactly DEB_SAMPLES−1 slots before a position-0 slot, starting from a setting of 2. A slot-by-slot model that reloads from the old setting then predicts which of the following frames are blanked, and every later slot's `seg` value shows whether the old or the new setting was used.

// File: rtl/led_scan_keys.sv
module led_scan_keys #(
  parameter int TICK_CYC    = 8200,
  parameter int SETTLE_CYC  = 4,
  parameter int DEB_SAMPLES = 64,
  parameter int BRIGHT_MAX  = 4,
  parameter int DP_DIGIT    = 2,
  parameter int LZ_STOP     = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [27:0] digit_codes,
  input  logic        lock_on,
  input  logic [1:0]  key_sense,
  output logic [6:0]  dig_en_n,
  output logic [7:0]  seg,
  output logic [1:0]  key_drv,
  output logic [3:0]  key_press
);
  localparam int TW = $clog2(TICK_CYC);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int DW = $clog2(DEB_SAMPLES + 1);
  localparam int BW = $clog2(BRIGHT_MAX + 1);

  typedef enum logic [1:0] {PH_SHOW, PH_GRP0, PH_GRP1} phase_t;

  phase_t        ph;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] scnt;
  logic [2:0]    dig, shown;
  logic          lit, lz;
  logic [BW-1:0] blink, bright;
  logic [1:0]    grp0;
  logic [3:0]    prev, deb;
  logic [DW-1:0] sc, sc_n;
  logic [7:0]    seg_q;

  function automatic logic [6:0] seg7(input logic [3:0] c);
    case (c)
      4'd0:    seg7 = 7'h3F;
      4'd1:    seg7 = 7'h06;
      4'd2:    seg7 = 7'h5B;
      4'd3:    seg7 = 7'h4F;
      4'd4:    seg7 = 7'h66;
      4'd5:    seg7 = 7'h6D;
      4'd6:    seg7 = 7'h7D;
      4'd7:    seg7 = 7'h07;
      4'd8:    seg7 = 7'h7F;
      4'd9:    seg7 = 7'h6F;
      4'd11:   seg7 = 7'h40;
      default: seg7 = 7'h00;
    endcase
  endfunction

  wire       tick     = (tcnt == TW'(TICK_CYC - 1));
  wire       settled  = (scnt == SW'(SETTLE_CYC - 1));
  wire [2:0] dsel     = (dig > 3'd6) ? 3'd6 : dig;
  wire [3:0] code     = digit_codes[{dsel, 2'b00} +: 4];
  wire       frame_on = (blink == '0);
  wire       lz_blank = lz && (dsel != 3'(LZ_STOP)) && (code == 4'd0);
  wire       dp_on    = frame_on && (lock_on || dsel == 3'(DP_DIGIT));
  wire [3:0] pat      = {key_sense, grp0};

  always_comb begin
    if (pat != prev)                    sc_n = DW'(1);
    else if (sc < DW'(DEB_SAMPLES))     sc_n = sc + 1'b1;
    else                                sc_n = sc;
  end

  wire       accept = (sc_n == DW'(DEB_SAMPLES)) && (pat != deb);
  wire [3:0] rise   = pat & ~deb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_SHOW;
      tcnt      <= '0;
      scnt      <= '0;
      dig       <= 3'd6;
      shown     <= 3'd6;
      lit       <= 1'b0;
      lz        <= 1'b1;
      blink     <= '0;
      bright    <= BW'(1);
      grp0      <= '0;
      prev      <= '0;
      deb       <= '0;
      sc        <= '0;
      seg_q     <= '0;
      key_press <= '0;
    end else begin
      tcnt      <= tick ? '0 : tcnt + 1'b1;
      key_press <= '0;
      case (ph)
        PH_SHOW: if (tick) begin
          ph   <= PH_GRP0;
          scnt <= '0;
        end
        PH_GRP0: if (settled) begin
          grp0 <= key_sense;
          ph   <= PH_GRP1;
          scnt <= '0;
        end else scnt <= scnt + 1'b1;
        PH_GRP1: if (settled) begin
          ph    <= PH_SHOW;
          lit   <= 1'b1;
          shown <= dsel;
          seg_q <= {dp_on, (frame_on && !lz_blank) ? seg7(code) : 7'h00};
          if (dsel == 3'd0) begin
            dig   <= 3'd6;
            lz    <= 1'b1;
            blink <= (frame_on ? bright : blink) - 1'b1;
          end else begin
            dig <= dsel - 1'b1;
            lz  <= lz_blank;
          end
          prev <= pat;
          sc   <= sc_n;
          if (accept) begin
            deb       <= pat;
            key_press <= rise;
            if (rise[0])
              bright <= (bright >= BW'(BRIGHT_MAX)) ? BW'(1) : bright + 1'b1;
          end
        end else scnt <= scnt + 1'b1;
        default: ph <= PH_SHOW;
      endcase
    end
  end

  assign key_drv  = (ph == PH_GRP0) ? 2'b01 : (ph == PH_GRP1) ? 2'b10 : 2'b00;
  assign dig_en_n = (ph == PH_SHOW && lit) ? ~(7'd1 << shown) : 7'h7F;
  assign seg      = (ph == PH_SHOW && lit) ? seg_q : 8'h00;

  assert_one_digit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) <= 1);
  assert_dig_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dig <= 3'd6);
  assert_dark_keyread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_drv != 2'b00) |-> (dig_en_n == 7'h7F && seg == 8'h00));
  assert_drv_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_drv));
  assert_press_accepted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_press & ~deb) == 4'd0);
  assert_press_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_press != 4'd0) |=> (key_press == 4'd0));
  assert_bright_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bright >= BW'(1)) && (bright <= BW'(BRIGHT_MAX)));
endmodule

// File: tb/tb_led_scan_keys.sv
`timescale 1ns/100ps
module tb_led_scan_keys;
  localparam int TICK = 12, SETTLE = 2, DEB = 4, BMAX = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [27:0] codes = '0;
  logic        lock = 1'b0;
  logic [3:0]  pat = '0;
  wire  [1:0]  key_sense;
  wire  [6:0]  dig_en_n;
  wire  [7:0]  seg;
  wire  [1:0]  key_drv;
  wire  [3:0]  key_press;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_dig = 6, m_lz = 1, m_blink = 0, m_bright = 1, m_prev = 0, m_deb = 0, m_sc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  assign key_sense = key_drv[0] ? pat[1:0] : key_drv[1] ? pat[3:2] : 2'b00;

  led_scan_keys #(.TICK_CYC(TICK), .SETTLE_CYC(SETTLE), .DEB_SAMPLES(DEB),
                  .BRIGHT_MAX(BMAX), .DP_DIGIT(2), .LZ_STOP(2)) dut (
    .clk(clk), .rst_n(rst_n), .digit_codes(codes), .lock_on(lock),
    .key_sense(key_sense), .dig_en_n(dig_en_n), .seg(seg),
    .key_drv(key_drv), .key_press(key_press));

  function automatic logic [6:0] shape(input int c);
    case (c)
      0: return 7'b0111111;  1: return 7'b0000110;  2: return 7'b1011011;
      3: return 7'b1001111;  4: return 7'b1100110;  5: return 7'b1101101;
      6: return 7'b1111101;  7: return 7'b0000111;  8: return 7'b1111111;
      9: return 7'b1101111;  11: return 7'b1000000;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_slot(input logic [3:0] p);
    int n0 = 0, n1 = 0, ds, code, on, lzb;
    logic dark = 1'b1;
    logic [7:0] e_seg;
    logic [6:0] e_en;
    logic [3:0] e_press = 4'd0;
    string tag;
    pat = p;
    while (key_drv != 2'b01) @(negedge clk);
    while (key_drv == 2'b01) begin
      n0++; if (dig_en_n != 7'h7F || seg != 8'h00) dark = 1'b0; @(negedge clk);
    end
    while (key_drv == 2'b10) begin
      n1++; if (dig_en_n != 7'h7F || seg != 8'h00) dark = 1'b0; @(negedge clk);
    end
    chk("R6", "drive timing/dark", {n0[7:0], n1[7:0], 7'd0, dark}, {8'(SETTLE), 8'(SETTLE), 8'd1});
    ds = m_dig;
    code = int'(codes[4*ds +: 4]);
    on = (m_blink == 0);
    lzb = (m_lz != 0 && ds != 2 && code == 0);
    e_seg = {on != 0 && (lock || ds == 2), (on != 0 && lzb == 0) ? shape(code) : 7'h00};
    e_en = ~(7'h01 << ds);
    chk("R1", "dig_en_n", 32'(dig_en_n), 32'(e_en));
    tag = (on == 0) ? "R5" : (seg[7] !== e_seg[7]) ? "R4" : (lzb != 0) ? "R3" : "R2";
    chk(tag, "seg", 32'(seg), 32'(e_seg));
    if (ds == 0) begin
      m_dig = 6; m_lz = 1;
      if (m_blink == 0) m_blink = m_bright;
      m_blink--;
    end else begin
      m_dig = ds - 1; m_lz = lzb;
    end
    if (int'(p) != m_prev) m_sc = 1; else if (m_sc < DEB) m_sc++;
    m_prev = int'(p);
    if (m_sc == DEB && int'(p) != m_deb) begin
      e_press = p & ~4'(m_deb);
      m_deb = int'(p);
    end
    if (e_press[0]) m_bright = (m_bright == BMAX) ? 1 : m_bright + 1;
    tag = (e_press[0] || key_press[0]) ? "R9" : (e_press != 0) ? "R8" : "R7";
    chk(tag, "key_press", 32'(key_press), 32'(e_press));
  endtask

  task automatic run_frames(input int n, input logic [3:0] p);
    for (int i = 0; i < 7 * n; i++) run_slot(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state before first slot
    chk("R10", "dig_en_n", 32'(dig_en_n), 32'h7F);
    chk("R10", "seg", 32'(seg), 32'h0);
    chk("R10", "key_drv", 32'(key_drv), 32'h0);
    chk("R10", "key_press", 32'(key_press), 32'h0);

    // R2: every code on every position (leading positions nonzero guard)
    for (int v = 0; v < 16; v++) begin
      codes = {7{4'(v)}};
      run_frames(1, 4'd0);
    end
    // R3 / R4: leading-zero depth sweep, with and without lock
    for (int lk = 0; lk < 2; lk++) begin
      lock = lk[0];
      for (int lead = 0; lead <= 7; lead++) begin
        for (int d = 0; d < 7; d++)
          codes[4*d +: 4] = (d >= 7 - lead) ? 4'd0 : 4'(((d + lead) % 9) + 1);
        run_frames(1, 4'd0);
        codes[4*(6 - lead % 7) +: 4] = 4'd0;
        codes[4*((lead + 3) % 7) +: 4] = 4'd10;
        run_frames(1, 4'd0);
      end
    end
    lock = 1'b0;
    codes = 28'h0012345;

    // R9 / R5: five dim presses walk 2,3,4,1,2 with frame blanking between
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < DEB + 3; i++) run_slot(4'b0001);
      for (int i = 0; i < DEB + 12; i++) run_slot(4'b0000);
    end
    // R9: dim acceptance coinciding with the position-0 frame reload
    while (m_dig != DEB - 1) run_slot(4'b0000);
    for (int i = 0; i < DEB; i++) run_slot(4'b0001);
    chk("R9", "bright after coincident press", 32'(m_bright), 32'd3);
    run_frames(8, 4'b0001);
    // R8: other keys, combined presses, release produces nothing
    for (int k = 1; k < 16; k++) begin
      for (int i = 0; i < DEB + 1; i++) run_slot(4'(k));
      for (int i = 0; i < DEB + 1; i++) run_slot(4'(k & 4'b1010));
    end
    // R7: bouncing patterns shorter than the window are never accepted
    for (int i = 0; i < 30; i++) run_slot((i % 3 == 0) ? 4'b0100 : 4'b0000);
    for (int i = 0; i < 30; i++) run_slot((i % DEB == DEB - 1) ? 4'b0000 : 4'b1000);

    // mixed sweep
    for (int f = 0; f < 120; f++) begin
      logic [15:0] r = rnd();
      codes = {rnd()[11:0], rnd()};
      if (r[3:0] < 4'd6) codes[27:24] = 4'd0;
      if (r[3:0] < 4'd3) codes[23:20] = 4'd0;
      lock = r[4];
      for (int s = 0; s < 7; s++) begin
        if (rnd()[2:0] == 3'd0) pat = rnd()[3:0];
        run_slot(pat);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule